// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Bring-Up and Readout Sequencer

This block is a synchronous serial master for an external sigma-delta converter that is controlled through byte commands. A `start_i` pulse starts a fixed bring-up. First the block drives a run of ones that returns the converter to its default state. It then waits a programmable settle time. Next it reads the converter status byte to prove that the link works and writes the host's filter and mode bytes. Last, it issues a single continuous-read command.

After bring-up, chip-select stays low. The shared data-out/ready line is watched, and each falling edge on it starts one 24-clock result frame, with no command byte in front of it. The captured word is presented on `sample_o` with a one-cycle `sample_vld_o` strobe. A status byte that reads back all zeros or all ones raises `err_o` and stops the sequence. A ready edge that does not arrive within the watchdog window also raises `err_o`, while readout keeps waiting.

The serial clock idles high. Its half-period is `div_i` system clocks. Data to the converter changes on falling edges and data from the converter is sampled on rising edges.

Top module: `sd_adc_sequencer`

## Requirements
- R1: After `start_i`, the first serial transfer is RST_BITS (32) clocks with chip-select low and data-to-converter held at 1 on every rising edge.
- R2: At least SETTLE_CYC system clocks pass between the last rising edge of the reset run and the first rising edge of the next transfer.
- R3: The status read is 16 clocks. Data-to-converter carries 0x04 (MSB first) and then eight ones. The eight bits sampled in the second byte, MSB first, appear on `status_o`.
- R4: If the status byte is 0x00 or 0xFF, `err_o` goes to 1, no further serial clocks are produced and chip-select returns high.
- R5: With a valid status, the block sends, in this order: {0x10, `filt_cfg_i`} (16 clocks), {0x08, `mode_cfg_i`} (16 clocks), then 0x3D (8 clocks), all MSB first.
- R6: From the 0x3D command onward, chip-select stays low. Each falling edge on `ser_miso_i` starts exactly 24 clocks with no command byte. The 24 bits sampled MSB first appear on `sample_o` with `sample_vld_o` high for exactly one cycle.
- R7: Serial clock and data-to-converter are high whenever no transfer runs, and data-to-converter stays 1 during status and result reads.
- R8: Each serial clock half-period is `div_i` system clocks, so the period is 2*`div_i`. A `div_i` of 0 acts as 1.
- R9: If no falling ready edge arrives within RDY_LIMIT system clocks of entering the wait for ready, `err_o` goes to 1.
- R10: While `rst_ni` is low, the serial clock, data-to-converter and chip-select are high, and `sample_vld_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts the bring-up sequence from idle or halt |
| div_i | input | DIV_W | Serial clock half-period in system clocks |
| filt_cfg_i | input | 8 | Byte written to the filter register |
| mode_cfg_i | input | 8 | Byte written to the mode register |
| ser_clk_o | output | 1 | Serial clock, idle high |
| ser_cs_n_o | output | 1 | Converter chip-select, active low |
| ser_mosi_o | output | 1 | Data to the converter |
| ser_miso_i | input | 1 | Data and ready indication from the converter |
| sample_o | output | RESULT_W | Last conversion result |
| sample_vld_o | output | 1 | One-cycle strobe for a new result |
| status_o | output | 8 | Status byte read during bring-up |
| err_o | output | 1 | Bad status byte or ready watchdog expired |

## Verification
If the sequencer state is wrong, the converter receives the wrong bits, and this shows within one transfer: a misplaced byte, a missing command or an extra command changes the serial bit stream logged at the serial-clock rising edges. A shift-engine count error changes the number of clocks per frame, and it also corrupts `sample_o` in the same frame. A fault in the settle timer or the watchdog shows as a shorter gap after the reset run, or as an `err_o` that rises too early or never, within one timer window. A fault in status handling shows as serial clocks continuing after a bad status byte.

// File: rtl/sd_adc_seq_pkg.sv
package sd_adc_seq_pkg;
   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_RESET,
      SQ_SETTLE,
      SQ_STATUS,
      SQ_FILT,
      SQ_MODE,
      SQ_CREAD,
      SQ_WAIT,
      SQ_FRAME,
      SQ_HALT
   } seq_state_e;

   localparam logic [7:0] FILL_ONES = 8'hFF;
endpackage

// File: rtl/sd_adc_seq_timer.sv
module sd_adc_seq_timer #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic [W-1:0] limit_i,
   output logic         hit_o
);
   logic [W-1:0] cnt_q;

   assign hit_o = (cnt_q >= limit_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (!hit_o) cnt_q <= cnt_q + 1'b1;
   end

   // R2 R9
   hit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_o && !clr_i) |=> hit_o);
endmodule

// File: rtl/sd_adc_seq_shift.sv
module sd_adc_seq_shift #(
   parameter int MAXB  = 32,
   parameter int DIV_W = 8,
   localparam int CW   = $clog2(MAXB + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             go_i,
   input  logic [CW-1:0]    nbits_i,
   input  logic [MAXB-1:0]  tx_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             miso_i,
   output logic             sclk_o,
   output logic             mosi_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [MAXB-1:0]  rx_o
);
   logic             busy_q, sclk_q, mosi_q, done_q;
   logic [DIV_W-1:0] half_q, half_lim;
   logic [CW-1:0]    left_q;
   logic [MAXB-1:0]  tx_q, rx_q;

   assign half_lim = (div_i == '0) ? DIV_W'(1) : div_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b1;
         mosi_q <= 1'b1;
         done_q <= 1'b0;
         half_q <= '0;
         left_q <= '0;
         tx_q   <= '0;
         rx_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (go_i) begin
               busy_q <= 1'b1;
               sclk_q <= 1'b0;
               mosi_q <= tx_i[MAXB-1];
               tx_q   <= tx_i << 1;
               left_q <= nbits_i;
               half_q <= DIV_W'(1);
               rx_q   <= '0;
            end
         end else if (half_q >= half_lim) begin
            half_q <= DIV_W'(1);
            if (!sclk_q) begin
               sclk_q <= 1'b1;
               rx_q   <= {rx_q[MAXB-2:0], miso_i};
               left_q <= left_q - 1'b1;
            end else if (left_q == '0) begin
               busy_q <= 1'b0;
               mosi_q <= 1'b1;
               done_q <= 1'b1;
            end else begin
               sclk_q <= 1'b0;
               mosi_q <= tx_q[MAXB-1];
               tx_q   <= tx_q << 1;
            end
         end else begin
            half_q <= half_q + 1'b1;
         end
      end
   end

   assign sclk_o = sclk_q;
   assign mosi_o = mosi_q;
   assign busy_o = busy_q;
   assign done_o = done_q;
   assign rx_o   = rx_q;

   // R7
   idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_q |-> (sclk_q && mosi_q));
   // R3
   done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |-> ($past(busy_q) && !busy_q));
endmodule

// File: rtl/sd_adc_sequencer.sv
module sd_adc_sequencer
   import sd_adc_seq_pkg::*;
#(
   parameter int         DIV_W      = 8,
   parameter int         RESULT_W   = 24,
   parameter int         RST_BITS   = 32,
   parameter int         SETTLE_CYC = 50000,
   parameter int         RDY_LIMIT  = 12000000,
   parameter int         RDY_SYNC   = 2,
   parameter logic [7:0] CMD_STATUS = 8'h04,
   parameter logic [7:0] CMD_FILT   = 8'h10,
   parameter logic [7:0] CMD_MODE   = 8'h08,
   parameter logic [7:0] CMD_CREAD  = 8'h3D
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                start_i,
   input  logic [DIV_W-1:0]    div_i,
   input  logic [7:0]          filt_cfg_i,
   input  logic [7:0]          mode_cfg_i,
   output logic                ser_clk_o,
   output logic                ser_cs_n_o,
   output logic                ser_mosi_o,
   input  logic                ser_miso_i,
   output logic [RESULT_W-1:0] sample_o,
   output logic                sample_vld_o,
   output logic [7:0]          status_o,
   output logic                err_o
);
   localparam int MAXB = (RST_BITS > RESULT_W) ? RST_BITS : RESULT_W;
   localparam int CW   = $clog2(MAXB + 1);
   localparam int SW   = $clog2(SETTLE_CYC + 1);
   localparam int WW   = $clog2(RDY_LIMIT + 1);

   if (MAXB < 16 || MAXB > 64) begin : g_bad_width
      $error("shift length must lie between 16 and 64 bits");
   end
   if (SETTLE_CYC < 1 || RDY_LIMIT < 1) begin : g_bad_timer
      $error("timer limits must be positive");
   end

   seq_state_e          state_q;
   logic                issued_q, err_q, vld_q;
   logic [7:0]          status_q;
   logic [RESULT_W-1:0] sample_q;
   logic                rdy_s, rdy_prev_q, rdy_fall;
   logic                eng_go, eng_busy, eng_done, eng_sclk, eng_mosi;
   logic [CW-1:0]       eng_nbits;
   logic [MAXB-1:0]     eng_tx, eng_rx;
   logic                xfer_st, reg_st, settle_hit, wd_hit;

   if (RDY_SYNC >= 2) begin : g_sync2
      logic meta_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            meta_q <= 1'b1;
            rdy_s  <= 1'b1;
         end else begin
            meta_q <= ser_miso_i;
            rdy_s  <= meta_q;
         end
      end
   end else begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) rdy_s <= 1'b1;
         else         rdy_s <= ser_miso_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rdy_prev_q <= 1'b1;
      else         rdy_prev_q <= rdy_s;
   end
   assign rdy_fall = rdy_prev_q && !rdy_s;

   assign reg_st  = (state_q == SQ_RESET) || (state_q == SQ_STATUS) ||
                    (state_q == SQ_FILT)  || (state_q == SQ_MODE);
   assign xfer_st = reg_st || (state_q == SQ_CREAD) || (state_q == SQ_FRAME);
   assign eng_go  = xfer_st && !issued_q;

   always_comb begin
      eng_nbits = CW'(16);
      eng_tx    = '1;
      unique case (state_q)
         SQ_RESET:  eng_nbits = CW'(RST_BITS);
         SQ_STATUS: eng_tx    = {CMD_STATUS, FILL_ONES, {(MAXB-16){1'b1}}};
         SQ_FILT:   eng_tx    = {CMD_FILT, filt_cfg_i, {(MAXB-16){1'b1}}};
         SQ_MODE:   eng_tx    = {CMD_MODE, mode_cfg_i, {(MAXB-16){1'b1}}};
         SQ_CREAD: begin
            eng_nbits = CW'(8);
            eng_tx    = {CMD_CREAD, {(MAXB-8){1'b1}}};
         end
         SQ_FRAME:  eng_nbits = CW'(RESULT_W);
         default: ;
      endcase
   end

   sd_adc_seq_shift #(.MAXB(MAXB), .DIV_W(DIV_W)) u_shift (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .go_i    (eng_go),
      .nbits_i (eng_nbits),
      .tx_i    (eng_tx),
      .div_i   (div_i),
      .miso_i  (ser_miso_i),
      .sclk_o  (eng_sclk),
      .mosi_o  (eng_mosi),
      .busy_o  (eng_busy),
      .done_o  (eng_done),
      .rx_o    (eng_rx)
   );

   sd_adc_seq_timer #(.W(SW)) u_settle (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (state_q != SQ_SETTLE),
      .limit_i (SW'(SETTLE_CYC)),
      .hit_o   (settle_hit)
   );

   sd_adc_seq_timer #(.W(WW)) u_watch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (state_q != SQ_WAIT),
      .limit_i (WW'(RDY_LIMIT)),
      .hit_o   (wd_hit)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= SQ_IDLE;
         issued_q <= 1'b0;
         err_q    <= 1'b0;
         vld_q    <= 1'b0;
         status_q <= '0;
         sample_q <= '0;
      end else begin
         vld_q <= 1'b0;
         if (xfer_st) begin
            if (!issued_q) begin
               issued_q <= 1'b1;
            end else if (eng_done) begin
               issued_q <= 1'b0;
               unique case (state_q)
                  SQ_RESET: state_q <= SQ_SETTLE;
                  SQ_STATUS: begin
                     status_q <= eng_rx[7:0];
                     if (eng_rx[7:0] == 8'h00 || eng_rx[7:0] == 8'hFF) begin
                        err_q   <= 1'b1;
                        state_q <= SQ_HALT;
                     end else begin
                        state_q <= SQ_FILT;
                     end
                  end
                  SQ_FILT:  state_q <= SQ_MODE;
                  SQ_MODE:  state_q <= SQ_CREAD;
                  SQ_CREAD: state_q <= SQ_WAIT;
                  default: begin
                     sample_q <= eng_rx[RESULT_W-1:0];
                     vld_q    <= 1'b1;
                     state_q  <= SQ_WAIT;
                  end
               endcase
            end
         end else begin
            unique case (state_q)
               SQ_SETTLE: if (settle_hit) state_q <= SQ_STATUS;
               SQ_WAIT: begin
                  if (wd_hit)   err_q   <= 1'b1;
                  if (rdy_fall) state_q <= SQ_FRAME;
               end
               default: if (start_i) begin
                  err_q   <= 1'b0;
                  state_q <= SQ_RESET;
               end
            endcase
         end
      end
   end

   assign ser_cs_n_o   = !((reg_st && issued_q) || (state_q == SQ_CREAD) ||
                           (state_q == SQ_WAIT) || (state_q == SQ_FRAME));
   assign ser_clk_o    = eng_sclk;
   assign ser_mosi_o   = eng_mosi;
   assign sample_o     = sample_q;
   assign sample_vld_o = vld_q;
   assign status_o     = status_q;
   assign err_o        = err_q;

   // R6
   clk_needs_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !eng_sclk |-> !ser_cs_n_o);
   // R6
   vld_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_q |=> !vld_q);
   // R4
   status_good_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == SQ_FILT && $past(state_q) == SQ_STATUS) |->
      (status_q != 8'h00 && status_q != 8'hFF));
   // R4
   halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == SQ_HALT) |-> (!eng_busy && ser_cs_n_o));
endmodule

// File: tb/sd_adc_sequencer_tb.sv
module sd_adc_sequencer_tb;
   localparam int SETTLE = 40;
   localparam int LIMIT  = 600;
   localparam int NVEC   = 6;
   localparam logic [23:0] VEC_WORD [NVEC] = '{24'h000000, 24'hFFFFFF, 24'h800001,
                                                24'h5A5A5A, 24'h123456, 24'hFEDCBA};
   localparam int          VEC_GAP  [NVEC] = '{10, 60, 25, 200, 5, 120};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [7:0] div = 8'd2;
   logic [7:0] filt = 8'h63;
   logic [7:0] mode = 8'h2E;
   logic sclk, cs_n, mosi, miso;
   logic [23:0] sample;
   logic vld, err;
   logic [7:0] status;

   int nchk = 0;
   int nerr = 0;
   int cyc = 0;
   int vld_cycles = 0;
   logic [23:0] last_sample = '0;

   int rises = 0;
   int fbase = 0;
   logic frame_on = 1'b0;
   logic model_dout = 1'b1;
   logic start_req = 1'b0;
   logic [7:0] stat_byte = 8'h5C;
   logic [23:0] cur_word = '0;
   logic bits_log [512];
   int   t_log [512];

   always #5 clk = ~clk;

   sd_adc_sequencer #(.SETTLE_CYC(SETTLE), .RDY_LIMIT(LIMIT)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .div_i(div),
      .filt_cfg_i(filt), .mode_cfg_i(mode), .ser_clk_o(sclk), .ser_cs_n_o(cs_n),
      .ser_mosi_o(mosi), .ser_miso_i(miso), .sample_o(sample),
      .sample_vld_o(vld), .status_o(status), .err_o(err));

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) if (vld) begin
      vld_cycles <= vld_cycles + 1;
      last_sample <= sample;
   end

   // converter model
   always @(posedge sclk or negedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         rises = 0; frame_on = 1'b0; fbase = 0; model_dout = 1'b1;
      end else if (sclk) begin
         if (rises < 512) begin bits_log[rises] = mosi; t_log[rises] = cyc; end
         rises++;
         if (frame_on && rises - fbase == 24) frame_on = 1'b0;
      end else begin
         if (start_req && !frame_on && !cs_n) begin frame_on = 1'b1; fbase = rises; end
         if (frame_on) model_dout = cur_word[23 - (rises - fbase)];
         else if (rises >= 40 && rises < 48) model_dout = stat_byte[7 - (rises - 40)];
      end
   end
   assign miso = frame_on ? model_dout :
                 ((rises >= 40 && rises < 48) ? model_dout : !start_req);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wait_rises(input int n);
      int k = 0;
      while (rises < n && k < 20000) begin @(negedge clk); k++; end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset;
      rst_n = 1'b0;
      idle(4);
      rst_n = 1'b1;
      idle(2);
   endtask

   task automatic pulse_start;
      start = 1'b1; idle(1); start = 1'b0;
   endtask

   function automatic logic [31:0] log_word(input int from, input int n);
      logic [31:0] w = '0;
      for (int i = 0; i < n; i++) w = {w[30:0], bits_log[from + i]};
      return w;
   endfunction

   task automatic run_frame(input logic [23:0] word, input int gap);
      int base, vbase, k;
      idle(gap);
      cur_word = word;
      base = rises;
      vbase = vld_cycles;
      start_req = 1'b1;
      k = 0;
      while (!frame_on && k < 2000) begin @(negedge clk); k++; end
      start_req = 1'b0;
      k = 0;
      while (vld_cycles == vbase && k < 2000) begin @(negedge clk); k++; end
      idle(2);
      chk(last_sample == word, "R6", "result word", {8'h0, last_sample}, {8'h0, word});
      chk(rises - base == 24, "R6", "clocks per frame", rises - base, 24);
      chk(vld_cycles - vbase == 1, "R6", "strobe cycles", vld_cycles - vbase, 1);
      chk(log_word(base, 24) == 32'h00FFFFFF, "R7", "mosi during frame",
          log_word(base, 24), 32'h00FFFFFF);
      chk(cs_n == 1'b0, "R6", "cs held low", cs_n, 0);
   endtask

   initial begin
      idle(3);
      chk({sclk, mosi, cs_n, vld, err} == 5'b11100, "R10", "reset outputs",
          {sclk, mosi, cs_n, vld, err}, 5'b11100);
      rst_n = 1'b1;
      idle(2);

      // bad status stops the sequence
      stat_byte = 8'hFF;
      pulse_start;
      wait_rises(48);
      idle(200);
      chk(err == 1'b1, "R4", "err after FF status", err, 1);
      chk(rises == 48, "R4", "no clocks after bad status", rises, 48);
      chk(cs_n == 1'b1 && sclk == 1'b1, "R4", "lines released", {cs_n, sclk}, 2'b11);

      do_reset;
      stat_byte = 8'h00;
      pulse_start;
      wait_rises(48);
      idle(200);
      chk(err == 1'b1 && rises == 48, "R4", "zero status halts", {err, 8'(rises)}, {1'b1, 8'd48});

      // good bring-up
      do_reset;
      stat_byte = 8'h5C;
      pulse_start;
      wait_rises(88);
      idle(20);
      chk(log_word(0, 32) == 32'hFFFFFFFF, "R1", "reset run", log_word(0, 32), 32'hFFFFFFFF);
      chk(t_log[32] - t_log[31] >= SETTLE, "R2", "settle gap", t_log[32] - t_log[31], SETTLE);
      chk(log_word(32, 16) == 32'h04FF, "R3", "status command", log_word(32, 16), 32'h04FF);
      chk(status == 8'h5C, "R3", "status byte", status, 8'h5C);
      chk(log_word(48, 16) == {16'h0, 8'h10, filt}, "R5", "filter write",
          log_word(48, 16), {16'h0, 8'h10, filt});
      chk(log_word(64, 16) == {16'h0, 8'h08, mode}, "R5", "mode write",
          log_word(64, 16), {16'h0, 8'h08, mode});
      chk(log_word(80, 8) == 32'h3D, "R5", "continuous command", log_word(80, 8), 32'h3D);
      chk(rises == 88, "R6", "no clocks before ready", rises, 88);
      chk(t_log[1] - t_log[0] == 4, "R8", "period div 2", t_log[1] - t_log[0], 4);
      chk(cs_n == 1'b0 && sclk && mosi, "R7", "idle in continuous mode",
          {cs_n, sclk, mosi}, 3'b011);
      chk(err == 1'b0, "R9", "no error yet", err, 0);

      for (int v = 0; v < NVEC; v++) run_frame(VEC_WORD[v], VEC_GAP[v]);
      chk(err == 1'b0, "R9", "no error with timely ready", err, 0);

      idle(LIMIT + 60);
      chk(err == 1'b1, "R9", "watchdog expired", err, 1);
      run_frame(24'h0F0F0F, 5);

      // divider of zero acts as one
      do_reset;
      div = 8'd0;
      pulse_start;
      wait_rises(3);
      chk(t_log[1] - t_log[0] == 2, "R8", "period div 0", t_log[1] - t_log[0], 2);
      do_reset;
      div = 8'd3;
      pulse_start;
      wait_rises(3);
      chk(t_log[2] - t_log[1] == 6, "R8", "period div 3", t_log[2] - t_log[1], 6);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      wait (cyc > 150000);
      nchk++; nerr++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule